// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

This block takes bytes from a serial receiver and stores them in memory buffers. Each buffer is described by a descriptor, and each descriptor holds a link to the next one, so the buffers form a chain. The host programs a high address byte that is shared by every descriptor, a pointer to the first descriptor, a pointer that marks where the chain ends, and a control word. The host then sets the enable bit. For each buffer the engine reads the descriptor and writes incoming bytes into the buffer. When the buffer is finished, the engine records the byte count and a status byte back into the descriptor. It then moves its current pointer to the linked descriptor without help from the host.

There are two modes. In single-frame mode the engine drops its own enable bit after the first frame has ended, and it waits for the host to set the bit again. In multi-frame mode it keeps going across frames. The only thing that stops it is a byte request that arrives while the current pointer equals the end pointer. That request is refused, enable drops, and a sticky end-of-chain flag is set. The flag can raise an interrupt.

Top module: `rxdma_chain`

## Requirements
- R1: After reset, rx_ready, mem_req and irq are low, and every register reads back as zero.
- R2: A descriptor is read at the 24-bit address {base register, current pointer} through byte reads at offsets 0 to 6, all little-endian. Offsets 0-1 hold the 16-bit link, offsets 2-4 hold the 24-bit buffer address, and offsets 5-6 hold the 16-bit buffer length.
- R3: Received bytes are written in arrival order to buffer address + n, where n counts from 0. rx_ready is high only while the engine waits for a byte, and never while mem_req is high.
- R4: A buffer is closed when its length is reached or when a byte arrives with rx_last set. A length of 0 stands for 65536 bytes. The engine then writes the byte count to descriptor offsets 5-6 (little-endian) and a status byte to offset 7. In the status byte, bit 7 means end of frame, bit 6 means buffer full, and all other bits are 0.
- R5: After the status write, the current pointer takes the link value read from the descriptor, with no host action.
- R6: In single-frame mode (control bit 1 = 0), the enable bit clears once a buffer closed by end-of-frame has been written back. After that, no byte is accepted and no memory access is made until the host sets enable again.
- R7: In multi-frame mode (control bit 1 = 1), the enable bit stays set after a frame ends, and the next frame continues in the linked buffer.
- R8: If rx_valid is high while enable is set and the current pointer equals the end pointer, the byte is not accepted and no descriptor is read. Enable clears and status bit 0 is set.
- R9: irq is high exactly when status bit 0 and control bit 2 are both set. Status bit 0 stays set until the host writes 1 to it. Writing 0 to it has no effect.
- R10: While mem_req is high and mem_ack is low, mem_addr, mem_we and mem_wdata keep their values into the next cycle, and mem_req stays high.
- R11: The register addresses are 0 base byte, 1 current pointer, 2 end pointer, 3 control (bit 0 enable, bit 1 multi-frame, bit 2 interrupt enable) and 4 status (bit 0 end of chain). Each one reads back on reg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| rx_valid | input | 1 | Receiver byte present (also the transfer request) |
| rx_data | input | 8 | Receiver byte |
| rx_last | input | 1 | Byte ends the frame |
| rx_ready | output | 1 | Engine takes the byte on this edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Access done |
| irq | output | 1 | End-of-chain interrupt |

## Verification
The bench builds the engine with its default widths: an 8-bit base, a 16-bit pointer and a 16-bit length. This gives a 7-byte descriptor fetch and a 3-byte writeback, so the little-endian split of every field appears at the memory port. At these widths a zero length means a 65536-byte buffer, and the test checks that a short frame still closes such a buffer at end-of-frame. A memory model whose acknowledge latency can be changed exercises both single-cycle and multi-cycle handshakes.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RECV,
      ST_WRITE,
      ST_WBACK
   } rxdma_state_e;

   localparam logic [2:0] RA_BASE = 3'd0;
   localparam logic [2:0] RA_CUR  = 3'd1;
   localparam logic [2:0] RA_END  = 3'd2;
   localparam logic [2:0] RA_CTL  = 3'd3;
   localparam logic [2:0] RA_STAT = 3'd4;

   localparam int SB_EOF  = 7;
   localparam int SB_FULL = 6;
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
   import rxdma_pkg::*;
#(
   parameter int BASE_W = 8,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [PTR_W-1:0]  wr_data,
   output logic [PTR_W-1:0]  rd_data,
   input  logic              cur_load,
   input  logic [PTR_W-1:0]  cur_next,
   input  logic              en_clr,
   input  logic              eoc_set,
   output logic [BASE_W-1:0] base_q,
   output logic [PTR_W-1:0]  cur_q,
   output logic [PTR_W-1:0]  end_q,
   output logic              en_q,
   output logic              multi_q,
   output logic              ie_q,
   output logic              irq
);
   logic eoc_q;
   logic wr_base, wr_cur, wr_end, wr_ctl, wr_stat;

   assign wr_base = wr_en && (wr_addr == RA_BASE);
   assign wr_cur  = wr_en && (wr_addr == RA_CUR);
   assign wr_end  = wr_en && (wr_addr == RA_END);
   assign wr_ctl  = wr_en && (wr_addr == RA_CTL);
   assign wr_stat = wr_en && (wr_addr == RA_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         cur_q   <= '0;
         end_q   <= '0;
         en_q    <= 1'b0;
         multi_q <= 1'b0;
         ie_q    <= 1'b0;
         eoc_q   <= 1'b0;
      end else begin
         if (wr_base) base_q <= wr_data[BASE_W-1:0];
         if (wr_end)  end_q  <= wr_data;
         // engine reload beats a simultaneous host write
         if (cur_load)    cur_q <= cur_next;
         else if (wr_cur) cur_q <= wr_data;
         if (wr_ctl) begin
            en_q    <= wr_data[0];
            multi_q <= wr_data[1];
            ie_q    <= wr_data[2];
         end
         if (en_clr) en_q <= 1'b0;
         if (eoc_set)                     eoc_q <= 1'b1;
         else if (wr_stat && wr_data[0])  eoc_q <= 1'b0;
      end
   end

   assign irq = eoc_q & ie_q;

   always_comb begin
      case (wr_addr)
         RA_BASE: rd_data = PTR_W'(base_q);
         RA_CUR:  rd_data = cur_q;
         RA_END:  rd_data = end_q;
         RA_CTL:  rd_data = PTR_W'({ie_q, multi_q, en_q});
         RA_STAT: rd_data = PTR_W'(eoc_q);
         default: rd_data = '0;
      endcase
   end

   AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cur_load) |-> (cur_q == $past(cur_next))); // R5
   AST_EOC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_q) |-> !en_q); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_q && !(wr_stat && wr_data[0])) |=> eoc_q); // R9
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
   import rxdma_pkg::*;
#(
   parameter int BASE_W = 8,
   parameter int PTR_W  = 16,
   parameter int LEN_W  = 16,
   localparam int AW    = BASE_W + PTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              multi,
   input  logic [BASE_W-1:0] base,
   input  logic [PTR_W-1:0]  cur,
   input  logic [PTR_W-1:0]  endp,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   output logic              rx_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [7:0]        mem_rdata,
   output logic              cur_load,
   output logic [PTR_W-1:0]  cur_next,
   output logic              en_clr,
   output logic              eoc_set
);
   localparam int LINK_B  = PTR_W / 8;
   localparam int ADDR_B  = AW / 8;
   localparam int LEN_B   = LEN_W / 8;
   localparam int FETCH_N = LINK_B + ADDR_B + LEN_B;
   localparam int WB_OFS  = LINK_B + ADDR_B;
   localparam int WB_N    = LEN_B + 1;
   localparam int IDX_W   = $clog2(FETCH_N);

   rxdma_state_e     state;
   logic [AW-1:0]    desc_addr;
   logic [IDX_W-1:0] idx;
   logic [7:0]       fbyte [FETCH_N];
   logic [LEN_W-1:0] count, count_n;
   logic [7:0]       hold_byte;
   logic             hold_last, eof_seen, full_seen;
   logic [PTR_W-1:0] link_w;
   logic [AW-1:0]    buf_w;
   logic [LEN_W-1:0] len_w;
   logic [7:0]       cnt_byte, status_byte;
   logic             at_end;

   genvar g;
   generate
      for (g = 0; g < LINK_B; g++) begin : g_link
         assign link_w[g*8 +: 8] = fbyte[g];
      end
      for (g = 0; g < ADDR_B; g++) begin : g_buf
         assign buf_w[g*8 +: 8] = fbyte[LINK_B + g];
      end
      for (g = 0; g < LEN_B; g++) begin : g_len
         assign len_w[g*8 +: 8] = fbyte[WB_OFS + g];
      end
   endgenerate

   assign count_n  = count + LEN_W'(1);
   assign at_end   = (cur == endp);
   assign cur_next = link_w;

   always_comb begin
      cnt_byte = '0;
      for (int k = 0; k < LEN_B; k++)
         if (idx == IDX_W'(k)) cnt_byte = count[k*8 +: 8];
      status_byte          = '0;
      status_byte[SB_EOF]  = eof_seen;
      status_byte[SB_FULL] = full_seen;
   end

   always_comb begin
      rx_ready  = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      cur_load  = 1'b0;
      en_clr    = 1'b0;
      eoc_set   = 1'b0;
      case (state)
         ST_IDLE: begin
            if (en && rx_valid && at_end) begin
               eoc_set = 1'b1;
               en_clr  = 1'b1;
            end
         end
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + AW'(idx);
         end
         ST_RECV: rx_ready = 1'b1;
         ST_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_w + AW'(count);
            mem_wdata = hold_byte;
         end
         ST_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_addr + AW'(WB_OFS) + AW'(idx);
            mem_wdata = (idx < IDX_W'(LEN_B)) ? cnt_byte : status_byte;
            if (mem_ack && idx == IDX_W'(WB_N - 1)) begin
               cur_load = 1'b1;
               en_clr   = eof_seen && !multi;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         desc_addr <= '0;
         idx       <= '0;
         count     <= '0;
         hold_byte <= '0;
         hold_last <= 1'b0;
         eof_seen  <= 1'b0;
         full_seen <= 1'b0;
         for (int k = 0; k < FETCH_N; k++) fbyte[k] <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (en && rx_valid && !at_end) begin
                  desc_addr <= {base, cur};
                  idx       <= '0;
                  state     <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  for (int k = 0; k < FETCH_N; k++)
                     if (idx == IDX_W'(k)) fbyte[k] <= mem_rdata;
                  if (idx == IDX_W'(FETCH_N - 1)) begin
                     count <= '0;
                     state <= ST_RECV;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            ST_RECV: begin
               if (rx_valid) begin
                  hold_byte <= rx_data;
                  hold_last <= rx_last;
                  state     <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  count <= count_n;
                  if (hold_last || count_n == len_w) begin
                     eof_seen  <= hold_last;
                     full_seen <= (count_n == len_w);
                     idx       <= '0;
                     state     <= ST_WBACK;
                  end else begin
                     state <= ST_RECV;
                  end
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  if (idx == IDX_W'(WB_N - 1)) state <= ST_IDLE;
                  else idx <= idx + IDX_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata))); // R10
   AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !rx_ready); // R3
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITE) |-> (len_w == '0 || count < len_w)); // R4
endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain
   import rxdma_pkg::*;
#(
   parameter int BASE_W = 8,
   parameter int PTR_W  = 16,
   parameter int LEN_W  = 16,
   localparam int AW    = BASE_W + PTR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [PTR_W-1:0] reg_wdata,
   output logic [PTR_W-1:0] reg_rdata,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_last,
   output logic             rx_ready,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [7:0]       mem_wdata,
   input  logic [7:0]       mem_rdata,
   input  logic             mem_ack,
   output logic             irq
);
   generate
      if (BASE_W % 8 != 0 || PTR_W % 8 != 0 || LEN_W % 8 != 0) begin : g_bad_align
         $error("rxdma_chain: widths must be whole bytes");
      end
      if (BASE_W > PTR_W || LEN_W > 32) begin : g_bad_size
         $error("rxdma_chain: base wider than pointer or length too wide");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic [PTR_W-1:0]  cur_q, end_q, cur_next;
   logic              en_q, multi_q, ie_q;
   logic              cur_load, en_clr, eoc_set;

   rxdma_regs #(.BASE_W(BASE_W), .PTR_W(PTR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .rd_data  (reg_rdata),
      .cur_load (cur_load),
      .cur_next (cur_next),
      .en_clr   (en_clr),
      .eoc_set  (eoc_set),
      .base_q   (base_q),
      .cur_q    (cur_q),
      .end_q    (end_q),
      .en_q     (en_q),
      .multi_q  (multi_q),
      .ie_q     (ie_q),
      .irq      (irq)
   );

   rxdma_engine #(.BASE_W(BASE_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .multi     (multi_q),
      .base      (base_q),
      .cur       (cur_q),
      .endp      (end_q),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_last   (rx_last),
      .rx_ready  (rx_ready),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .cur_load  (cur_load),
      .cur_next  (cur_next),
      .en_clr    (en_clr),
      .eoc_set   (eoc_set)
   );
endmodule

// File: tb/sim_rxdma_chain.sv
module sim_rxdma_chain;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_last = 1'b0;
   logic        rx_ready;
   logic        mem_req, mem_we;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        irq;

   logic [7:0] mem [0:4095];
   int lat = 0, wcnt = 0;
   int n_chk = 0, n_bad = 0;
   int acc_cnt = 0, mreq_cnt = 0, bad_hi = 0;
   logic [7:0] exp_hi = 8'h12;
   bit timeout = 0;

   always #2.5 clk = ~clk;

   rxdma_chain u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
   );

   always @(posedge clk) begin
      if (rx_valid && rx_ready) acc_cnt <= acc_cnt + 1;
      if (mem_req) begin
         mreq_cnt <= mreq_cnt + 1;
         if (mem_addr[23:16] !== exp_hi) bad_hi <= bad_hi + 1;
      end
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (wcnt >= lat) begin
            mem_ack <= 1'b1;
            wcnt    <= 0;
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic check_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic put_desc(input int at, input logic [15:0] link,
                           input logic [23:0] bufa, input logic [15:0] len);
      mem[at]   = link[7:0];  mem[at+1] = link[15:8];
      mem[at+2] = bufa[7:0];  mem[at+3] = bufa[15:8]; mem[at+4] = bufa[23:16];
      mem[at+5] = len[7:0];   mem[at+6] = len[15:8];  mem[at+7] = 8'h00;
   endtask

   task automatic send(input logic [7:0] b, input logic l);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; rx_last = l;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic settle();
      repeat (40) @(negedge clk);
   endtask

   task automatic offer_refused(input string req);
      int a0, m0;
      a0 = acc_cnt; m0 = mreq_cnt;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h5A; rx_last = 1'b1;
      repeat (20) @(negedge clk);
      check({req, " byte accepted"}, acc_cnt - a0, 0);
      check({req, " memory cycles"}, mreq_cnt - m0, 0);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R1 rx_ready", rx_ready, 0);
      check("R1 mem_req", mem_req, 0);
      check("R1 irq", irq, 0);
      for (int a = 0; a < 5; a++) check_reg("R1 register", 3'(a), 16'h0);
   endtask

   task automatic test_single();
      put_desc(12'h100, 16'h0108, 24'h120400, 16'd16);
      put_desc(12'h108, 16'h0110, 24'h120480, 16'd4);
      wr(3'd0, 16'h0012); wr(3'd1, 16'h0100); wr(3'd2, 16'h0200);
      wr(3'd3, 16'h0001);
      for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i), i == 4);
      settle();
      for (int i = 0; i < 5; i++) check("R3 buffer byte", mem[12'h400 + i], 8'hA0 + 8'(i));
      check("R3 past end untouched", mem[12'h405], 8'h00);
      check("R4 count low", mem[12'h105], 8'd5);
      check("R4 count high", mem[12'h106], 8'd0);
      check("R4 status eof", mem[12'h107], 8'h80);
      check_reg("R5 cur reload", 3'd1, 16'h0108);
      check_reg("R6 enable cleared", 3'd3, 16'h0000);
      check("R2 high address byte", bad_hi, 0);
      check_reg("R11 base", 3'd0, 16'h0012);
      check_reg("R11 end", 3'd2, 16'h0200);
      offer_refused("R6 disabled");
      wr(3'd3, 16'h0001);
      send(8'h77, 1'b1);
      settle();
      check("R6 restart byte", mem[12'h480], 8'h77);
      check("R6 restart status", mem[12'h10F], 8'h80);
      check_reg("R6 cleared again", 3'd3, 16'h0000);
      check_reg("R5 cur second", 3'd1, 16'h0110);
   endtask

   task automatic test_multi();
      put_desc(12'h110, 16'h0118, 24'h120500, 16'd3);
      put_desc(12'h118, 16'h0120, 24'h120600, 16'd8);
      put_desc(12'h120, 16'h0128, 24'h120700, 16'd2);
      wr(3'd2, 16'h0128);
      wr(3'd3, 16'h0007);
      for (int i = 0; i < 5; i++) send(8'hB0 + 8'(i), i == 4);
      settle();
      for (int i = 0; i < 3; i++) check("R3 first buffer", mem[12'h500 + i], 8'hB0 + 8'(i));
      for (int i = 0; i < 2; i++) check("R3 chained buffer", mem[12'h600 + i], 8'hB3 + 8'(i));
      check("R4 full status", mem[12'h117], 8'h40);
      check("R4 full count", mem[12'h115], 8'd3);
      check("R4 eof status", mem[12'h11F], 8'h80);
      check("R4 eof count", mem[12'h11D], 8'd2);
      check_reg("R7 enable kept", 3'd3, 16'h0007);
      send(8'hC0, 1'b0); send(8'hC1, 1'b1);
      settle();
      check("R7 second frame", mem[12'h701], 8'hC1);
      check("R4 full and eof", mem[12'h127], 8'hC0);
      check_reg("R5 cur at end", 3'd1, 16'h0128);
      check("R8 irq before", irq, 0);
      offer_refused("R8 end of chain");
      check("R8 irq", irq, 1);
      check_reg("R8 status flag", 3'd4, 16'h0001);
      check_reg("R8 enable cleared", 3'd3, 16'h0006);
      wr(3'd4, 16'h0000);
      check_reg("R9 write 0 keeps flag", 3'd4, 16'h0001);
      wr(3'd4, 16'h0001);
      check_reg("R9 flag cleared", 3'd4, 16'h0000);
      check("R9 irq cleared", irq, 0);
   endtask

   task automatic test_noirq();
      wr(3'd3, 16'h0003);
      offer_refused("R8 masked");
      check_reg("R9 flag set masked", 3'd4, 16'h0001);
      check("R9 irq masked", irq, 0);
      wr(3'd4, 16'h0001);
   endtask

   task automatic test_latency();
      lat = 3;
      put_desc(12'h128, 16'h0130, 24'h120800, 16'd4);
      put_desc(12'h130, 16'h0138, 24'h120900, 16'd0);
      wr(3'd2, 16'h0200);
      wr(3'd3, 16'h0003);
      for (int i = 0; i < 6; i++) send(8'hD0 + 8'(i), i == 5);
      settle();
      for (int i = 0; i < 4; i++) check("R10 slow write", mem[12'h800 + i], 8'hD0 + 8'(i));
      check("R4 slow full status", mem[12'h12F], 8'h40);
      check("R4 slow count", mem[12'h12D], 8'd4);
      check("R4 zero length buffer", mem[12'h901], 8'hD5);
      check("R4 zero length status", mem[12'h137], 8'h80);
      check("R4 zero length count", mem[12'h135], 8'd2);
      check_reg("R5 slow cur", 3'd1, 16'h0138);
      check("R2 high byte slow", bad_hi, 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      fork
         begin
            test_reset();
            test_single();
            test_multi();
            test_noirq();
            test_latency();
         end
         begin
            repeat (100000) @(posedge clk);
            timeout = 1;
         end
      join_any
      disable fork;
      if (timeout) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule